// File: doc/BRIEF.md
# Per-Access Policy Set-Associative Data Cache

This block is a write-back/write-through data cache that sits between a CPU load/store port and a simple line-oriented memory port. Attribute bits that arrive with each request choose the policy for that access alone. One bit says whether the access is cacheable at all. A second bit chooses write-back or write-through. A third bit chooses whether a write miss allocates a line. The cache is set-associative. The number of ways, the number of sets, the line size and the address width are all parameters. The default build is 32 ways of 32 sets, with 32-byte lines on 32-byte boundaries.

Each set keeps a round-robin victim pointer, and the search for a victim skips locked ways. A lock command brings a line into the cache if it is not already there and pins it. Software can therefore turn part of the cache into fixed on-chip RAM that never misses. If every way of a set is locked, accesses to that set are handled without allocation. A dirty bit per line records write-back updates. A dirty victim is written back as a whole line before its refill is requested.

The CPU side accepts one request while idle and answers with a one-cycle response pulse. The memory side issues one operation at a time and holds it until memory acknowledges it.

Top module: `dcache_policy`

## Requirements
- R1: After reset `req_ready` is 1, `mem_valid` is 0 and `rsp_valid` is 0. `req_ready` is never 1 while a memory operation is pending.
- R2: A read that hits returns the addressed word on `rsp_rdata` during a one-cycle `rsp_valid` pulse and issues no memory operation.
- R3: A cacheable read miss (`req_attr[0]`=1) issues exactly one line read and installs the line, so the next read of that line hits.
- R4: A write hit with `req_attr[1]`=1 (write-back) updates only the cache line and marks it dirty. It issues no memory operation and leaves memory unchanged.
- R5: When the victim line is dirty, its full line is written to memory, and only after that is the line read for the refill requested. Memory then holds the written data.
- R6: A write with `req_attr[1]`=0 (write-through) that hits, or that has just allocated, updates the line and issues one word write to memory.
- R7: A write miss with `req_attr[2]`=0 (read-allocate) issues one word write, no line read, and installs nothing, so a later read of that line still misses.
- R8: A write miss with `req_attr[2]`=1 (read-write-allocate) reads and installs the line, then applies the write under the write policy in force.
- R9: A non-cacheable access (`req_attr[0]`=0) never fills the cache. Each read issues a line read and returns the addressed word. Each write issues a word write.
- R10: Victims in a set are chosen round-robin. The pointer moves to the way after the one just filled, and locked ways are skipped.
- R11: A request with `req_lock`=1 is treated as a cacheable read. It installs the line if absent and marks it locked. A locked line is never chosen as a victim, so later accesses to it hit.
- R12: When all ways of a set are locked, misses in that set do not allocate. Reads go to memory every time, and writes become word writes.
- R13: `req_be[i]` enables byte lane i, bits 8i+7 to 8i, of the addressed word, both in the cache line and in a memory word write.
- R14: `mem_op` encodes 0 as line read, 1 as line write and 2 as word write. A request holds `mem_op` and `mem_addr` stable until `mem_ready`. Line operations use line-aligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_lock | input | 1 | Lock command for the addressed line |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Byte lane enables |
| req_attr | input | 3 | [0] cacheable, [1] write-back, [2] write-allocate |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Load data (0 for stores) |
| mem_valid | output | 1 | Memory operation pending |
| mem_ready | input | 1 | Memory completes the operation this cycle |
| mem_op | output | 2 | 0 line read, 1 line write, 2 word write |
| mem_addr | output | AW | Line address or word byte address |
| mem_wline | output | LINE_BYTES*8 | Line data for a line write |
| mem_wdata | output | DW | Word data for a word write |
| mem_be | output | DW/8 | Byte enables for a word write |
| mem_rline | input | LINE_BYTES*8 | Line data returned with `mem_ready` on a line read |

## Verification
Each kind of internal fault shows at the ports in its own way. A lost dirty bit shows as stale data on the first read after that line is evicted and refilled. A wrongly set dirty bit shows as a line write on the memory port where none is due. A round-robin pointer that is wrong, or that does not skip locked ways, changes which later access misses. That surfaces one access later, as an extra or a missing line read, and for a locked line as a miss that must never occur. A policy bit that is decoded wrongly shows in the operation mix of the very same access: a word write where none belongs, or a line read on a read-allocate write miss. The bench counts every memory operation per access and compares every load against a flat memory model.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
   localparam int ATTR_CACHE  = 0;
   localparam int ATTR_WB     = 1;
   localparam int ATTR_WALLOC = 2;

   typedef enum logic [1:0] {
      MEM_LINE_RD = 2'd0,
      MEM_LINE_WR = 2'd1,
      MEM_WORD_WR = 2'd2
   } mem_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_LOOK, S_EVICT, S_FILL, S_BYP_RD, S_WORD_WR
   } dc_state_e;
endpackage

// File: rtl/dc_way_match.sv
`timescale 1ns/1ps
module dc_way_match #(
   parameter int WAYS  = 32,
   parameter int TAG_W = 22,
   localparam int WIDX = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            valid,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit,
   output logic [WIDX-1:0]            way
);
   logic [WAYS-1:0] match;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == tag);
   end

   assign hit = |match;

   always_comb begin
      way = '0;
      for (int i = WAYS-1; i >= 0; i--) begin
         if (match[i]) way = WIDX'(i);
      end
   end
endmodule

// File: rtl/dc_rr_victim.sv
`timescale 1ns/1ps
module dc_rr_victim #(
   parameter int WAYS = 32,
   localparam int WIDX = $clog2(WAYS)
) (
   input  logic [WIDX-1:0] ptr,
   input  logic [WAYS-1:0] locked,
   output logic [WIDX-1:0] victim,
   output logic            none
);
   always_comb begin
      logic [WIDX-1:0] idx;
      victim = ptr;
      none   = 1'b1;
      for (int k = WAYS-1; k >= 0; k--) begin
         idx = ptr + WIDX'(k);
         if (!locked[idx]) begin
            victim = idx;
            none   = 1'b0;
         end
      end
   end
endmodule

// File: rtl/dc_line_merge.sv
`timescale 1ns/1ps
module dc_line_merge #(
   parameter int DW  = 32,
   parameter int WPL = 8,
   localparam int BPW  = DW / 8,
   localparam int WSEL = $clog2(WPL),
   localparam int LW   = DW * WPL
) (
   input  logic [LW-1:0]   line_i,
   input  logic [WSEL-1:0] sel,
   input  logic [DW-1:0]   wdata,
   input  logic [BPW-1:0]  be,
   output logic [LW-1:0]   line_o
);
   for (genvar w = 0; w < WPL; w++) begin : g_word
      for (genvar b = 0; b < BPW; b++) begin : g_byte
         assign line_o[(w*BPW+b)*8 +: 8] = (sel == WSEL'(w) && be[b])
                                           ? wdata[b*8 +: 8]
                                           : line_i[(w*BPW+b)*8 +: 8];
      end
   end
endmodule

// File: rtl/dcache_policy.sv
`timescale 1ns/1ps
module dcache_policy
   import dcache_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int WAYS       = 32,
   parameter int SETS       = 32,
   parameter int LINE_BYTES = 32,
   localparam int BPW   = DW / 8,
   localparam int WPL   = LINE_BYTES / BPW,
   localparam int LW    = LINE_BYTES * 8,
   localparam int OFS   = $clog2(LINE_BYTES),
   localparam int WOF   = $clog2(BPW),
   localparam int WSEL  = $clog2(WPL),
   localparam int SIDX  = $clog2(SETS),
   localparam int WIDX  = $clog2(WAYS),
   localparam int TAG_W = AW - OFS - SIDX
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_write,
   input  logic           req_lock,
   input  logic [DW-1:0]  req_wdata,
   input  logic [BPW-1:0] req_be,
   input  logic [2:0]     req_attr,
   output logic           rsp_valid,
   output logic [DW-1:0]  rsp_rdata,
   output logic           mem_valid,
   input  logic           mem_ready,
   output logic [1:0]     mem_op,
   output logic [AW-1:0]  mem_addr,
   output logic [LW-1:0]  mem_wline,
   output logic [DW-1:0]  mem_wdata,
   output logic [BPW-1:0] mem_be,
   input  logic [LW-1:0]  mem_rline
);
   // elaboration checks on the geometry
   if (WAYS < 2 || (WAYS & (WAYS-1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS-1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (DW % 8 != 0 || WPL < 2 || (WPL & (WPL-1)) != 0) begin : g_bad_line
      $error("line must hold a power-of-two count (>=2) of whole-byte words");
   end
   if (TAG_W < 1) begin : g_bad_aw
      $error("address too narrow for the geometry");
   end

   dc_state_e          st;
   logic [AW-1:0]      r_addr;
   logic               r_write, r_lock;
   logic [DW-1:0]      r_wdata;
   logic [BPW-1:0]     r_be;
   logic [2:0]         r_attr;
   logic [WIDX-1:0]    vic_q;

   logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
   logic [WAYS-1:0]            val_q   [SETS];
   logic [WAYS-1:0]            dirty_q [SETS];
   logic [WAYS-1:0]            lock_q  [SETS];
   logic [WIDX-1:0]            rr_q    [SETS];
   logic [LW-1:0]              data_q  [SETS][WAYS];

   wire [SIDX-1:0]  r_set  = r_addr[OFS +: SIDX];
   wire [TAG_W-1:0] r_tag  = r_addr[AW-1 -: TAG_W];
   wire [WSEL-1:0]  r_word = r_addr[WOF +: WSEL];

   logic            hit, no_victim;
   logic [WIDX-1:0] hit_way, victim;
   logic [LW-1:0]   cur_line, merged;

   dc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .tags(tag_q[r_set]), .valid(val_q[r_set]), .tag(r_tag),
      .hit(hit), .way(hit_way));

   dc_rr_victim #(.WAYS(WAYS)) u_victim (
      .ptr(rr_q[r_set]), .locked(lock_q[r_set]),
      .victim(victim), .none(no_victim));

   assign cur_line = data_q[r_set][hit_way];

   dc_line_merge #(.DW(DW), .WPL(WPL)) u_merge (
      .line_i(cur_line), .sel(r_word), .wdata(r_wdata), .be(r_be),
      .line_o(merged));

   // lookup decision
   dc_state_e look_next;
   logic      look_done, wr_hit_en, lock_en, fill_en, evict_done;
   wire       in_look   = (st == S_LOOK);
   wire       cacheable = r_attr[ATTR_CACHE] | r_lock;
   wire       want_alloc = ~r_write | r_attr[ATTR_WALLOC];

   always_comb begin
      look_next = S_IDLE;
      look_done = 1'b0;
      wr_hit_en = 1'b0;
      lock_en   = 1'b0;
      if (!cacheable) begin
         look_next = r_write ? S_WORD_WR : S_BYP_RD;
      end else if (hit) begin
         if (r_write) begin
            wr_hit_en = in_look;
            if (r_attr[ATTR_WB]) look_done = 1'b1;
            else                 look_next = S_WORD_WR;
         end else begin
            lock_en   = in_look & r_lock;
            look_done = 1'b1;
         end
      end else if (want_alloc && !no_victim) begin
         look_next = (val_q[r_set][victim] && dirty_q[r_set][victim]) ? S_EVICT : S_FILL;
      end else begin
         look_next = r_write ? S_WORD_WR : S_BYP_RD;
      end
   end

   assign fill_en    = (st == S_FILL)  && mem_ready;
   assign evict_done = (st == S_EVICT) && mem_ready;

   // control path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         r_addr    <= '0;
         r_write   <= 1'b0;
         r_lock    <= 1'b0;
         r_wdata   <= '0;
         r_be      <= '0;
         r_attr    <= '0;
         vic_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               r_addr  <= req_addr;
               r_write <= req_write & ~req_lock;
               r_lock  <= req_lock;
               r_wdata <= req_wdata;
               r_be    <= req_be;
               r_attr  <= req_attr;
               st      <= S_LOOK;
            end
            S_LOOK: begin
               vic_q <= victim;
               st    <= look_next;
               if (look_done) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= r_write ? '0 : cur_line[r_word*DW +: DW];
               end
            end
            S_EVICT: if (mem_ready) st <= S_FILL;
            S_FILL:  if (mem_ready) st <= S_LOOK;
            S_BYP_RD: if (mem_ready) begin
               rsp_valid <= 1'b1;
               rsp_rdata <= mem_rline[r_word*DW +: DW];
               st        <= S_IDLE;
            end
            S_WORD_WR: if (mem_ready) begin
               rsp_valid <= 1'b1;
               rsp_rdata <= '0;
               st        <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // line state bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s]   <= '0;
            dirty_q[s] <= '0;
            lock_q[s]  <= '0;
            rr_q[s]    <= '0;
         end
      end else begin
         if (evict_done) dirty_q[r_set][vic_q] <= 1'b0;
         if (fill_en) begin
            val_q[r_set][vic_q]   <= 1'b1;
            dirty_q[r_set][vic_q] <= 1'b0;
            lock_q[r_set][vic_q]  <= 1'b0;
            rr_q[r_set]           <= vic_q + WIDX'(1);
         end
         if (wr_hit_en && r_attr[ATTR_WB]) dirty_q[r_set][hit_way] <= 1'b1;
         if (lock_en) lock_q[r_set][hit_way] <= 1'b1;
      end
   end

   // tag and data arrays
   always_ff @(posedge clk) begin
      if (fill_en) begin
         data_q[r_set][vic_q] <= mem_rline;
         tag_q[r_set][vic_q]  <= r_tag;
      end
      if (wr_hit_en) data_q[r_set][hit_way] <= merged;
   end

   // memory port
   always_comb begin
      mem_valid = 1'b0;
      mem_op    = MEM_LINE_RD;
      mem_addr  = {r_tag, r_set, OFS'(0)};
      case (st)
         S_EVICT: begin
            mem_valid = 1'b1;
            mem_op    = MEM_LINE_WR;
            mem_addr  = {tag_q[r_set][vic_q], r_set, OFS'(0)};
         end
         S_FILL, S_BYP_RD: mem_valid = 1'b1;
         S_WORD_WR: begin
            mem_valid = 1'b1;
            mem_op    = MEM_WORD_WR;
            mem_addr  = r_addr;
         end
         default: ;
      endcase
   end

   assign mem_wline = data_q[r_set][vic_q];
   assign mem_wdata = r_wdata;
   assign mem_be    = r_be;
   assign req_ready = (st == S_IDLE);
endmodule

// File: rtl/dcache_policy_chk.sv
`timescale 1ns/1ps
module dcache_policy_chk #(
   parameter int AW  = 32,
   parameter int OFS = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [1:0]    mem_op,
   input logic [AW-1:0] mem_addr,
   input logic          fill_en,
   input logic          vic_locked
);
   AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_valid);                                           // R1
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);                                           // R2
   AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && mem_op == 2'd1) |=> (mem_valid && mem_op == 2'd0)); // R5
   AST_NO_LOCKED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !vic_locked);                                            // R11
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_op) && $stable(mem_addr))); // R14
   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_op != 2'd2) |-> (mem_addr[OFS-1:0] == '0));        // R14
endmodule

bind dcache_policy dcache_policy_chk #(.AW(AW), .OFS(OFS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_op(mem_op),
   .mem_addr(mem_addr), .fill_en(fill_en),
   .vic_locked(lock_q[r_set][vic_q]));

// File: tb/test_dcache_policy.sv
`timescale 1ns/1ps
module test_dcache_policy;
   localparam int AW = 14, DW = 32, WAYS = 4, SETS = 4, LB = 32;
   localparam int LW = LB * 8, WPL = LB / 4, MW = (1 << AW) / 4;
   localparam logic [2:0] A_NC = 3'b000, A_WT_RA = 3'b001, A_WB_RA = 3'b011;
   localparam logic [2:0] A_WT_RWA = 3'b101, A_WB_RWA = 3'b111;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, req_valid, req_ready, req_write, req_lock, rsp_valid;
   logic [AW-1:0] req_addr, mem_addr;
   logic [DW-1:0] req_wdata, rsp_rdata, mem_wdata;
   logic [3:0] req_be, mem_be;
   logic [2:0] req_attr;
   logic mem_valid, mem_ready;
   logic [1:0] mem_op;
   logic [LW-1:0] mem_wline, mem_rline;

   dcache_policy #(.AW(AW), .DW(DW), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LB)) i_dcache_policy (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_lock(req_lock),
      .req_wdata(req_wdata), .req_be(req_be), .req_attr(req_attr),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_op(mem_op), .mem_addr(mem_addr),
      .mem_wline(mem_wline), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rline(mem_rline));

   logic [31:0] bmem [MW];   // backing memory seen by the memory port
   logic [31:0] rmem [MW];   // CPU-visible reference model
   int n_tests = 0, n_fail = 0, n_rsp = 0;
   int cnt_lrd = 0, cnt_lwr = 0, cnt_wwr = 0, prev_op = -1, last_op = -1;
   int s_lrd, s_lwr, s_wwr, wc = 0;
   logic [31:0] exp_q [$];
   bit chk_q [$];
   string rq_q [$];

   task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // memory responder: one wait cycle, then acknowledge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready = 1'b0; wc = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
      end else if (mem_valid) begin
         if (wc < 1) wc++;
         else begin
            int li, wi;
            wc = 0;
            li = int'(mem_addr) / LB;
            wi = int'(mem_addr) / 4;
            prev_op = last_op; last_op = int'(mem_op);
            case (mem_op)
               2'd0: begin
                  for (int w = 0; w < WPL; w++) mem_rline[w*32 +: 32] = bmem[li*WPL + w];
                  cnt_lrd++;
               end
               2'd1: begin
                  for (int w = 0; w < WPL; w++) bmem[li*WPL + w] = mem_wline[w*32 +: 32];
                  cnt_lwr++;
               end
               default: begin
                  for (int b = 0; b < 4; b++) if (mem_be[b]) bmem[wi][b*8 +: 8] = mem_wdata[b*8 +: 8];
                  cnt_wwr++;
               end
            endcase
            mem_ready = 1'b1;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected response", rsp_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            bit c;
            string r;
            e = exp_q.pop_front(); c = chk_q.pop_front(); r = rq_q.pop_front();
            if (c) check(rsp_rdata === e, r, rsp_rdata, e);
         end
         n_rsp++;
      end
   end

   task automatic req(input logic [AW-1:0] a, input bit wr, input bit lk, input logic [31:0] d,
                      input logic [3:0] be, input logic [2:0] at, input string r);
      int start, wi;
      wi = int'(a) / 4;
      exp_q.push_back(rmem[wi]); chk_q.push_back(!wr || lk); rq_q.push_back(r);
      if (wr && !lk)
         for (int b = 0; b < 4; b++) if (be[b]) rmem[wi][b*8 +: 8] = d[b*8 +: 8];
      start = n_rsp;
      @(negedge clk);
      req_addr = a; req_write = wr; req_lock = lk; req_wdata = d; req_be = be; req_attr = at;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (n_rsp == start) @(negedge clk);
   endtask

   task automatic snap();
      s_lrd = cnt_lrd; s_lwr = cnt_lwr; s_wwr = cnt_wwr;
   endtask

   task automatic ops(input string r, input int lrd, input int lwr, input int wwr);
      check(cnt_lrd - s_lrd == lrd, {r, " line reads"}, cnt_lrd - s_lrd, lrd);
      check(cnt_lwr - s_lwr == lwr, {r, " line writes"}, cnt_lwr - s_lwr, lwr);
      check(cnt_wwr - s_wwr == wwr, {r, " word writes"}, cnt_wwr - s_wwr, wwr);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [2:0] at, input string r);
      req(a, 1'b0, 1'b0, 32'h0, 4'hF, at, r);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be,
                     input logic [2:0] at, input string r);
      req(a, 1'b1, 1'b0, d, be, at, r);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < MW; i++) begin
         bmem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
         rmem[i] = bmem[i];
      end
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_lock = 1'b0;
      req_wdata = '0; req_be = '0; req_attr = '0; mem_ready = 1'b0; mem_rline = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
      check(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
      check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);

      // R3 / R2: fill then hit (set 0)
      snap(); rd(14'h0000, A_WB_RWA, "R3 miss data"); ops("R3 R14 read miss", 1, 0, 0);
      snap(); rd(14'h0004, A_WB_RWA, "R2 hit data");  ops("R2 read hit", 0, 0, 0);

      // R4: write-back hit stays in cache
      snap(); wr(14'h0008, 32'h1122_3344, 4'hF, A_WB_RWA, "R4 write");
      ops("R4 write-back hit", 0, 0, 0);
      check(bmem[2] != 32'h1122_3344, "R4 memory untouched", bmem[2], 32'h0);
      rd(14'h0008, A_WB_RWA, "R4 readback");

      // R5 / R10: fill the set, dirty way 0 is evicted
      rd(14'h0080, A_WB_RWA, "R10 fill way1");
      rd(14'h0100, A_WB_RWA, "R10 fill way2");
      rd(14'h0180, A_WB_RWA, "R10 fill way3");
      snap(); rd(14'h0200, A_WB_RWA, "R5 new line data"); ops("R5 dirty evict", 1, 1, 0);
      check(prev_op == 1 && last_op == 0, "R5 write-back before refill", prev_op, 1);
      check(bmem[2] == 32'h1122_3344, "R5 memory got dirty data", bmem[2], 32'h1122_3344);
      snap(); rd(14'h0008, A_WB_RWA, "R5 refetched data"); ops("R10 way1 victim", 1, 0, 0);
      snap(); rd(14'h0100, A_WB_RWA, "R10 way2 kept");     ops("R10 way2 hit", 0, 0, 0);
      snap(); rd(14'h0080, A_WB_RWA, "R10 way1 gone");     ops("R10 evicted line misses", 1, 0, 0);

      // R6: write-through hit (set 1)
      rd(14'h0020, A_WT_RA, "R6 fill");
      snap(); wr(14'h0024, 32'hDEAD_0001, 4'hF, A_WT_RA, "R6 write");
      ops("R6 write-through hit", 0, 0, 1);
      check(bmem[9] == 32'hDEAD_0001, "R6 memory updated", bmem[9], 32'hDEAD_0001);
      snap(); rd(14'h0024, A_WT_RA, "R6 readback"); ops("R6 readback hit", 0, 0, 0);

      // R7 / R8 (set 2)
      snap(); wr(14'h0048, 32'h0BAD_F00D, 4'hF, A_WB_RA, "R7 write");
      ops("R7 read-allocate write miss", 0, 0, 1);
      check(bmem[18] == 32'h0BAD_F00D, "R7 memory updated", bmem[18], 32'h0BAD_F00D);
      snap(); rd(14'h0048, A_WB_RA, "R7 readback"); ops("R7 line not installed", 1, 0, 0);
      snap(); wr(14'h00C4, 32'h7777_1234, 4'hF, A_WT_RWA, "R8 write");
      ops("R8 allocate then write-through", 1, 0, 1);
      snap(); rd(14'h00C4, A_WT_RWA, "R8 readback"); ops("R8 line installed", 0, 0, 0);

      // R9 / R13 (set 3)
      snap(); rd(14'h0060, A_NC, "R9 bypass data"); ops("R9 bypass read", 1, 0, 0);
      snap(); rd(14'h0060, A_NC, "R9 bypass again"); ops("R9 no fill", 1, 0, 0);
      snap(); wr(14'h0064, 32'hCAFE_BEEF, 4'b0011, A_NC, "R9 write");
      ops("R9 bypass write", 0, 0, 1);
      rd(14'h0064, A_NC, "R13 partial word write");
      wr(14'h0070, 32'h5A5A_5A5A, 4'b1010, A_WB_RWA, "R13 cached write");
      rd(14'h0070, A_WB_RWA, "R13 partial line merge");
      snap(); rd(14'h0064, A_WB_RWA, "R13 neighbour word"); ops("R13 hit after merge", 0, 0, 0);

      // R11: lock line 0x0020 in set 1, then stream other lines
      snap(); req(14'h0020, 1'b0, 1'b1, 32'h0, 4'hF, A_WT_RA, "R11 lock data");
      ops("R11 lock of resident line", 0, 0, 0);
      rd(14'h00A0, A_WB_RWA, "R11 stream a");
      rd(14'h0120, A_WB_RWA, "R11 stream b");
      rd(14'h01A0, A_WB_RWA, "R11 stream c");
      rd(14'h0220, A_WB_RWA, "R11 stream d");
      rd(14'h02A0, A_WB_RWA, "R11 stream e");
      snap(); rd(14'h0024, A_WT_RA, "R11 locked data"); ops("R11 locked line hits", 0, 0, 0);

      // R12: lock remaining ways of set 1
      req(14'h0320, 1'b0, 1'b1, 32'h0, 4'hF, A_WB_RWA, "R12 lock 1");
      req(14'h03A0, 1'b0, 1'b1, 32'h0, 4'hF, A_WB_RWA, "R12 lock 2");
      req(14'h0420, 1'b0, 1'b1, 32'h0, 4'hF, A_WB_RWA, "R12 lock 3");
      snap(); rd(14'h04A0, A_WB_RWA, "R12 read data"); ops("R12 read no alloc", 1, 0, 0);
      snap(); rd(14'h04A0, A_WB_RWA, "R12 read data 2"); ops("R12 read still misses", 1, 0, 0);
      snap(); rd(14'h0320, A_WB_RWA, "R12 locked data"); ops("R12 locked line hits", 0, 0, 0);
      snap(); wr(14'h0524, 32'h3141_5926, 4'hF, A_WB_RWA, "R12 write");
      ops("R12 write no alloc", 0, 0, 1);
      rd(14'h0524, A_WB_RWA, "R12 write reached memory");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R2 outstanding responses", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule